// File: doc/BRIEF.md
# Paged Internal Data Address Decoder

This block takes one access per clock into an 8-bit internal data space and resolves it. The bottom half of the space (0x00 to 0x7F) is ordinary RAM, which is reachable in either addressing mode. The top half (0x80 to 0xFF) has two separate backings. An indirect access reaches a second 128-byte RAM. A direct access reaches a special-function-register (SFR) bank. The current value of an 8-bit page register picks which SFR bank is used, so the space can hold up to 256 of them. The block holds both RAM halves, the SFR banks and the page register. It also reports the route and two region flags for the access on the same cycle.

The page register sits at direct address `PAGE_REG_ADDR` (0x84 by default). It is visible from every page, so software can always move to another page. `NUM_PAGES` sets how many SFR banks have storage behind them (default 4). A page number at or above that count selects an empty bank. Reads from an empty bank return 0x00, and writes to it are dropped.

A small response machine has two states, `ST_IDLE` and `ST_RESP`, and it produces the read strobe. Transition `IDLE_TO_RESP` happens on an enabled read. Transition `RESP_TO_RESP` happens on back-to-back reads. Transition `RESP_TO_IDLE` happens on a cycle with no read. The machine stays in `ST_IDLE` while no read arrives. `rd_valid` is high exactly in `ST_RESP`.

Top module: `idata_page_decoder`

## Requirements
- R1: After reset, and after any later reset, `page_sel` is 0x00, `rd_valid` is 0 and `rd_data` is 0x00.
- R2: When `acc_addr` is below 0x80, `region` is 0 (lower RAM) in both addressing modes.
- R3: When `acc_addr` is 0x80 or above and `acc_indirect` is 1, `region` is 1 (upper RAM).
- R4: When `acc_addr` is 0x80 or above and `acc_indirect` is 0, `region` is 2 (SFR).
- R5: `gpr_hit` is 1 exactly for addresses 0x00 to 0x1F. `bit_hit` is 1 exactly for addresses 0x20 to 0x2F. Both flags ignore the addressing mode, and they are never high together.
- R6: An enabled read (`acc_en`=1, `acc_write`=0) raises `rd_valid` in the next cycle, with the byte on `rd_data`. In any other cycle, `rd_valid` is 0 one cycle later and `rd_data` keeps its value.
- R7: Lower RAM is a single store: a byte written in one mode is read back in the other mode.
- R8: The upper RAM byte and the SFR byte at the same address are separate storage.
- R9: A direct write to 0x84 loads `page_sel` at that clock edge, from every page. A direct read of 0x84 returns the page. An indirect access to 0x84 reaches upper RAM.
- R10: SFR bytes at the same address are kept separately for each page. The page value that holds during an access selects the bank.
- R11: With a page number of `NUM_PAGES` or more, SFR reads return 0x00 and SFR writes leave every bank unchanged.
- R12: With `acc_en` at 0, no write to RAM, SFR or the page register takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | An access is present this cycle |
| acc_addr | input | 8 | Internal data address |
| acc_indirect | input | 1 | 1 = indirect addressing, 0 = direct |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_wdata | input | 8 | Write byte |
| rd_data | output | 8 | Read byte, one cycle after the read |
| rd_valid | output | 1 | `rd_data` was loaded by the previous cycle's read |
| region | output | 2 | Route: 0 lower RAM, 1 upper RAM, 2 SFR |
| gpr_hit | output | 1 | Address is in the general-register region |
| bit_hit | output | 1 | Address is in the bit-addressable region |
| page_sel | output | 8 | Current SFR page |

## Verification
A page register that holds a wrong value does not show on `page_sel` alone. It shows on the first direct read of a shared SFR address, because that read then returns another page's byte one cycle later. The bench therefore gives different pages different contents at the same offset, and it reads them back after every page change. A wrong response state shows within one cycle as a misplaced `rd_valid` pulse, or as `rd_data` changing after a write or an idle cycle. Aliasing between the upper RAM and the SFR banks shows on the first read-back of 0x80, 0x84 and 0x90 in the other addressing mode.

// File: rtl/idata_pkg.sv
`timescale 1ns/1ps
package idata_pkg;

    typedef enum logic [1:0] {
        RGN_LOWER = 2'd0,
        RGN_UPPER = 2'd1,
        RGN_SFR   = 2'd2
    } region_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } resp_state_e;

    localparam logic [7:0] GPR_LAST   = 8'h1F;
    localparam logic [7:0] BITA_FIRST = 8'h20;
    localparam logic [7:0] BITA_LAST  = 8'h2F;

endpackage

// File: rtl/idata_route.sv
`timescale 1ns/1ps
module idata_route
    import idata_pkg::*;
#(
    parameter int ADDR_W = 8,
    localparam int OFF_W = ADDR_W - 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              indirect,
    output region_e           rgn,
    output logic              gpr_hit,
    output logic              bit_hit,
    output logic [OFF_W-1:0]  offset
);

    logic top_half;

    always_comb begin
        top_half = addr[ADDR_W-1];
        offset   = addr[OFF_W-1:0];
        if (!top_half) begin
            rgn = RGN_LOWER;
        end else if (indirect) begin
            rgn = RGN_UPPER;
        end else begin
            rgn = RGN_SFR;
        end
        gpr_hit = (addr <= ADDR_W'(GPR_LAST));
        bit_hit = (addr >= ADDR_W'(BITA_FIRST)) && (addr <= ADDR_W'(BITA_LAST));
    end

endmodule

// File: rtl/idata_byte_ram.sv
`timescale 1ns/1ps
module idata_byte_ram #(
    parameter int DEPTH  = 128,
    parameter int DATA_W = 8,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/idata_sfr_pages.sv
`timescale 1ns/1ps
module idata_sfr_pages #(
    parameter int          NUM_PAGES    = 4,
    parameter int          OFF_W        = 7,
    parameter int          DATA_W       = 8,
    parameter int          PAGE_W       = 8,
    parameter logic [6:0]  PAGE_REG_OFF = 7'h04,
    localparam int         SLOTS        = 1 << OFF_W,
    localparam int         IDX_W        = $clog2(NUM_PAGES * SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr,
    input  logic [OFF_W-1:0]  off,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [PAGE_W-1:0] page_sel
);

    logic [DATA_W-1:0] bank [NUM_PAGES * SLOTS];
    logic [PAGE_W-1:0] page_q;
    logic              is_page_reg;
    logic              page_ok;
    logic              page_wr;
    logic              bank_wr;
    logic [IDX_W-1:0]  idx;

    always_comb begin
        is_page_reg = (off == OFF_W'(PAGE_REG_OFF));
        page_ok     = (int'(page_q) < NUM_PAGES);
        page_wr     = sel && wr && is_page_reg;
        bank_wr     = sel && wr && !is_page_reg && page_ok;
        idx         = IDX_W'({page_q, off});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q <= '0;
        end else if (page_wr) begin
            page_q <= wdata[PAGE_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (bank_wr) begin
            bank[idx] <= wdata;
        end
    end

    always_comb begin
        if (is_page_reg) begin
            rdata = DATA_W'(page_q);
        end else if (page_ok) begin
            rdata = bank[idx];
        end else begin
            rdata = '0;
        end
    end

    assign page_sel = page_q;

    // R9: page register loads the written byte
    p_page_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        page_wr |=> (page_q == $past(wdata[PAGE_W-1:0])));

    // R12 / R9: page register moves only on its own write
    p_page_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !page_wr |=> $stable(page_q));

endmodule

// File: rtl/idata_page_decoder.sv
`timescale 1ns/1ps
module idata_page_decoder
    import idata_pkg::*;
#(
    parameter int         DATA_W        = 8,
    parameter int         NUM_PAGES     = 4,
    parameter logic [7:0] PAGE_REG_ADDR = 8'h84
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic [7:0]        acc_addr,
    input  logic              acc_indirect,
    input  logic              acc_write,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [1:0]        region,
    output logic              gpr_hit,
    output logic              bit_hit,
    output logic [7:0]        page_sel
);

    localparam int ADDR_W  = 8;
    localparam int OFF_W   = ADDR_W - 1;
    localparam int HALF    = 1 << OFF_W;
    localparam int N_RAMS  = 2;

    region_e           rgn;
    logic [OFF_W-1:0]  off;
    logic              rd_req;
    logic              wr_req;
    logic [N_RAMS-1:0] ram_we;
    logic [DATA_W-1:0] ram_rdata [N_RAMS];
    logic [DATA_W-1:0] sfr_rdata;
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] rd_data_q;
    resp_state_e       state_q, state_d;

    idata_route #(.ADDR_W(ADDR_W)) u_route (
        .addr     (acc_addr),
        .indirect (acc_indirect),
        .rgn      (rgn),
        .gpr_hit  (gpr_hit),
        .bit_hit  (bit_hit),
        .offset   (off)
    );

    assign rd_req = acc_en && !acc_write;
    assign wr_req = acc_en && acc_write;

    // one RAM half per route code: index 0 lower, index 1 upper
    for (genvar g = 0; g < N_RAMS; g++) begin : g_ram
        assign ram_we[g] = wr_req && (rgn == region_e'(g));
        idata_byte_ram #(.DEPTH(HALF), .DATA_W(DATA_W)) u_ram (
            .clk   (clk),
            .wr_en (ram_we[g]),
            .addr  (off),
            .wdata (acc_wdata),
            .rdata (ram_rdata[g])
        );
    end

    idata_sfr_pages #(
        .NUM_PAGES    (NUM_PAGES),
        .OFF_W        (OFF_W),
        .DATA_W       (DATA_W),
        .PAGE_W       (8),
        .PAGE_REG_OFF (PAGE_REG_ADDR[6:0])
    ) u_sfr (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (acc_en && (rgn == RGN_SFR)),
        .wr       (acc_write),
        .off      (off),
        .wdata    (acc_wdata),
        .rdata    (sfr_rdata),
        .page_sel (page_sel)
    );

    always_comb begin
        unique case (rgn)
            RGN_LOWER: rd_mux = ram_rdata[0];
            RGN_UPPER: rd_mux = ram_rdata[1];
            RGN_SFR:   rd_mux = sfr_rdata;
            default:   rd_mux = '0;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            rd_data_q <= '0;
        end else begin
            state_q <= state_d;
            if (rd_req) begin
                rd_data_q <= rd_mux;
            end
        end
    end

    // next state: IDLE_TO_RESP, RESP_TO_RESP, RESP_TO_IDLE
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = rd_req ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = rd_req ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        rd_valid = (state_q == ST_RESP);
        rd_data  = rd_data_q;
        region   = rgn;
    end

    p_lower_route_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_addr[7] |-> (region == 2'd0));

    p_upper_route_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_addr[7] && acc_indirect) |-> (region == 2'd1));

    p_sfr_route_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_addr[7] && !acc_indirect) |-> (region == 2'd2));

    p_flags_apart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(gpr_hit && bit_hit));

    p_valid_after_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid);

    p_no_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rd_valid);

    p_data_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> $stable(rd_data));

    p_ram_write_en_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_en |-> (ram_we == '0));

endmodule

// File: tb/idata_page_decoder_bench.sv
`timescale 1ns/1ps
module idata_page_decoder_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_en = 1'b0;
    logic [7:0] acc_addr = '0;
    logic       acc_indirect = 1'b0;
    logic       acc_write = 1'b0;
    logic [7:0] acc_wdata = '0;
    logic [7:0] rd_data;
    logic       rd_valid;
    logic [1:0] region;
    logic       gpr_hit;
    logic       bit_hit;
    logic [7:0] page_sel;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    idata_page_decoder u_idata_page_decoder (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_addr(acc_addr),
        .acc_indirect(acc_indirect), .acc_write(acc_write), .acc_wdata(acc_wdata),
        .rd_data(rd_data), .rd_valid(rd_valid), .region(region),
        .gpr_hit(gpr_hit), .bit_hit(bit_hit), .page_sel(page_sel)
    );

    // {write, indirect, addr, wdata, expected read, region, gpr, bit}
    localparam int NV = 41;
    localparam logic [29:0] VEC [NV] = '{
        {1'b1,1'b0,8'h05,8'h11,8'h00,2'd0,1'b1,1'b0},
        {1'b0,1'b1,8'h05,8'h00,8'h11,2'd0,1'b1,1'b0},
        {1'b1,1'b1,8'h25,8'h22,8'h00,2'd0,1'b0,1'b1},
        {1'b0,1'b0,8'h25,8'h00,8'h22,2'd0,1'b0,1'b1},
        {1'b1,1'b1,8'h90,8'h33,8'h00,2'd1,1'b0,1'b0},
        {1'b1,1'b0,8'h90,8'h44,8'h00,2'd2,1'b0,1'b0},
        {1'b0,1'b1,8'h90,8'h00,8'h33,2'd1,1'b0,1'b0},
        {1'b0,1'b0,8'h90,8'h00,8'h44,2'd2,1'b0,1'b0},
        {1'b1,1'b0,8'h84,8'h01,8'h00,2'd2,1'b0,1'b0},
        {1'b0,1'b0,8'h84,8'h00,8'h01,2'd2,1'b0,1'b0},
        {1'b1,1'b0,8'h90,8'h55,8'h00,2'd2,1'b0,1'b0},
        {1'b0,1'b0,8'h90,8'h00,8'h55,2'd2,1'b0,1'b0},
        {1'b1,1'b1,8'h84,8'h66,8'h00,2'd1,1'b0,1'b0},
        {1'b0,1'b1,8'h84,8'h00,8'h66,2'd1,1'b0,1'b0},
        {1'b0,1'b0,8'h84,8'h00,8'h01,2'd2,1'b0,1'b0},
        {1'b1,1'b0,8'h84,8'h00,8'h00,2'd2,1'b0,1'b0},
        {1'b0,1'b0,8'h90,8'h00,8'h44,2'd2,1'b0,1'b0},
        {1'b1,1'b0,8'h84,8'h09,8'h00,2'd2,1'b0,1'b0},
        {1'b1,1'b0,8'h90,8'h77,8'h00,2'd2,1'b0,1'b0},
        {1'b0,1'b0,8'h90,8'h00,8'h00,2'd2,1'b0,1'b0},
        {1'b0,1'b0,8'h84,8'h00,8'h09,2'd2,1'b0,1'b0},
        {1'b1,1'b0,8'h84,8'h01,8'h00,2'd2,1'b0,1'b0},
        {1'b0,1'b0,8'h90,8'h00,8'h55,2'd2,1'b0,1'b0},
        {1'b1,1'b0,8'h84,8'h00,8'h00,2'd2,1'b0,1'b0},
        {1'b1,1'b1,8'h7F,8'h88,8'h00,2'd0,1'b0,1'b0},
        {1'b0,1'b0,8'h7F,8'h00,8'h88,2'd0,1'b0,1'b0},
        {1'b1,1'b0,8'h1F,8'hAA,8'h00,2'd0,1'b1,1'b0},
        {1'b0,1'b1,8'h1F,8'h00,8'hAA,2'd0,1'b1,1'b0},
        {1'b1,1'b0,8'h20,8'hBB,8'h00,2'd0,1'b0,1'b1},
        {1'b1,1'b0,8'h2F,8'hCC,8'h00,2'd0,1'b0,1'b1},
        {1'b0,1'b1,8'h20,8'h00,8'hBB,2'd0,1'b0,1'b1},
        {1'b0,1'b0,8'h2F,8'h00,8'hCC,2'd0,1'b0,1'b1},
        {1'b1,1'b1,8'h30,8'hDD,8'h00,2'd0,1'b0,1'b0},
        {1'b0,1'b0,8'h30,8'h00,8'hDD,2'd0,1'b0,1'b0},
        {1'b1,1'b1,8'hFF,8'hEE,8'h00,2'd1,1'b0,1'b0},
        {1'b0,1'b1,8'hFF,8'h00,8'hEE,2'd1,1'b0,1'b0},
        {1'b1,1'b0,8'h80,8'h5A,8'h00,2'd2,1'b0,1'b0},
        {1'b0,1'b0,8'h80,8'h00,8'h5A,2'd2,1'b0,1'b0},
        {1'b1,1'b1,8'h80,8'hA5,8'h00,2'd1,1'b0,1'b0},
        {1'b0,1'b1,8'h80,8'h00,8'hA5,2'd1,1'b0,1'b0},
        {1'b0,1'b0,8'h80,8'h00,8'h5A,2'd2,1'b0,1'b0}
    };

    task automatic chk(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [7:0] last_rd;
        logic [7:0] cur_page;
        last_rd  = 8'h00;
        cur_page = 8'h00;

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "page_sel at reset", page_sel, 8'h00);
        chk("R1", "rd_valid at reset", {7'd0, rd_valid}, 8'h00);
        chk("R1", "rd_data at reset", rd_data, 8'h00);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [29:0] v;
            string rtag;
            string dtag;
            v = VEC[i];
            @(negedge clk);
            acc_en       = 1'b1;
            acc_write    = v[29];
            acc_indirect = v[28];
            acc_addr     = v[27:20];
            acc_wdata    = v[19:12];
            #1;
            rtag = (v[3:2] == 2'd0) ? "R2" : (v[3:2] == 2'd1) ? "R3" : "R4";
            chk(rtag, "region", {6'd0, region}, {6'd0, v[3:2]});
            chk("R5", "gpr_hit", {7'd0, gpr_hit}, {7'd0, v[1]});
            chk("R5", "bit_hit", {7'd0, bit_hit}, {7'd0, v[0]});
            if (!v[27])                   dtag = "R7";
            else if (v[28])               dtag = "R8";
            else if (v[27:20] == 8'h84)   dtag = "R9";
            else if (cur_page >= 8'd4)    dtag = "R11";
            else                          dtag = "R10";
            @(posedge clk);
            #1;
            if (!v[29]) begin
                chk("R6", "rd_valid after read", {7'd0, rd_valid}, 8'h01);
                chk(dtag, "read byte", rd_data, v[11:4]);
                last_rd = v[11:4];
            end else begin
                chk("R6", "rd_valid after write", {7'd0, rd_valid}, 8'h00);
                chk("R6", "rd_data hold after write", rd_data, last_rd);
                if (!v[28] && v[27:20] == 8'h84) begin
                    cur_page = v[19:12];
                    chk("R9", "page_sel after load", page_sel, cur_page);
                end
            end
        end

        // R12: disabled writes to RAM and page register
        @(negedge clk);
        acc_en = 1'b0; acc_write = 1'b1; acc_indirect = 1'b0;
        acc_addr = 8'h05; acc_wdata = 8'h99;
        @(posedge clk); #1;
        chk("R6", "rd_valid idle", {7'd0, rd_valid}, 8'h00);
        chk("R6", "rd_data hold idle", rd_data, last_rd);
        @(negedge clk);
        acc_addr = 8'h84; acc_wdata = 8'h03;
        @(posedge clk); #1;
        chk("R12", "page_sel after disabled write", page_sel, 8'h00);
        @(negedge clk);
        acc_en = 1'b1; acc_write = 1'b0; acc_addr = 8'h05;
        @(posedge clk); #1;
        chk("R12", "lower RAM after disabled write", rd_data, 8'h11);
        @(negedge clk);
        acc_addr = 8'h90;
        @(posedge clk); #1;
        chk("R12", "page 0 SFR after disabled page write", rd_data, 8'h44);

        // R1: reset in mid-run
        @(negedge clk);
        acc_write = 1'b1; acc_addr = 8'h84; acc_wdata = 8'h02;
        @(posedge clk); #1;
        chk("R9", "page_sel loaded 2", page_sel, 8'h02);
        @(negedge clk);
        acc_en = 1'b0; acc_write = 1'b0;
        rst_n = 1'b0;
        #1;
        chk("R1", "page_sel after reset", page_sel, 8'h00);
        chk("R1", "rd_valid after reset", {7'd0, rd_valid}, 8'h00);
        chk("R1", "rd_data after reset", rd_data, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        summary();
    end

endmodule